// File: doc/BRIEF.md
# Linear Systolic Matrix-Vector Multiplier

This block computes the product y = A·v of a small square signed matrix and a signed vector on a one-dimensional chain of multiply-accumulate cells. Each cell holds one vector element in a stationary coefficient register. Software loads these registers through a write port while the array is idle. During streaming, each cell multiplies the matrix element on its lane by its coefficient, adds the partial sum that arrives from its left neighbour, and registers the result toward its right neighbour. The leftmost cell starts from zero. The finished dot product leaves the rightmost cell together with a valid flag.

The matrix arrives skewed. When a row starts in cycle t, its element for column k must be on lane k in cycle t+k. Every lane with nothing scheduled is driven with zero. Rows may follow each other back to back, and once the chain is full one result leaves per cycle.

A three-state controller guards the coefficient registers. It has the following states and transitions:
- LOAD accepts coefficient writes. A row start moves it to STREAM.
- STREAM stays in STREAM while rows keep starting. A cycle with no row start moves it to DRAIN.
- DRAIN returns to STREAM on a new row start. It falls back to LOAD once no row is left in flight.

Top module: `smv_array`

## Requirements
- R1: Each valid result equals the exact signed sum over k of A[i][k]·v[k], using two's-complement DATA_W-bit operands. The sum is given in ACC_W = 2·DATA_W + ceil(log2 N) bits, so even all-extreme operands do not overflow.
- R2: A row whose start is flagged by `row_start` in cycle t produces its result on `y_data`, with `y_valid` high, after exactly N rising clock edges.
- R3: Rows started in consecutive cycles produce results in consecutive cycles, in the same order. `y_valid` is low in every cycle that carries no result.
- R4: Element A[i][k] must be presented on lane k (bits k·DATA_W upward of `a_lanes`) in cycle t+k. Idle lanes carry zero, and zero lanes add nothing to any result.
- R5: After reset, `y_valid` is 0, `y_data` is 0, every coefficient is 0 and the controller is in LOAD.
- R6: A coefficient write (`vec_wr` high) is accepted only when the controller is in LOAD and `row_start` is low in that cycle. It stores `vec_data` into coefficient `vec_idx`.
- R7: Coefficient writes are ignored in STREAM and DRAIN, and in a LOAD cycle that starts a row. Results keep using the old coefficients.
- R8: A write with `vec_idx` ≥ N changes no coefficient.
- R9: The controller moves between states as follows:
  - LOAD goes to STREAM on `row_start`.
  - STREAM goes to DRAIN when `row_start` is low.
  - DRAIN goes back to STREAM on `row_start`.
  - DRAIN goes to LOAD in the edge after the first cycle with no row in flight.
  
  As a result, after the last row starts in cycle c, a write is first accepted in cycle c+N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_wr | input | 1 | Coefficient write strobe |
| vec_idx | input | IDX_W | Coefficient (cell) index for the write |
| vec_data | input | DATA_W | Signed coefficient value |
| row_start | input | 1 | A new row's column-0 element is on lane 0 this cycle |
| a_lanes | input | N×DATA_W | Skewed matrix elements, one signed lane per cell, zero when idle |
| y_valid | output | 1 | `y_data` holds a finished dot product |
| y_data | output | ACC_W | Signed dot product from the rightmost cell |

## Verification
A row started in cycle t is due N rising edges later. The bench drives each cycle's inputs on the falling edge and samples after the following rising edge, so it can compute, for every cycle, which row (if any) must be on the output. It then compares both `y_valid` and the data against that row's arithmetic sum. The coefficient guard is timed around the same count: relative to the last row start c, the bench issues writes in cycles c+N and c+N+1, which must be dropped, and in cycle c+N+2, which must land. The next stream's results reveal which of those writes took effect.

// File: rtl/smv_pkg.sv
package smv_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } smv_state_e;

endpackage

// File: rtl/smv_cell.sv
module smv_cell #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] coef,
    input  logic [ACC_W-1:0]  psum_in,
    output logic [ACC_W-1:0]  psum_out
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x;

    always_comb begin
        prod   = $signed(a_in) * $signed(coef);
        prod_x = ACC_W'(prod);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psum_out <= '0;
        end else begin
            psum_out <= psum_in + prod_x;
        end
    end
endmodule

// File: rtl/smv_ctrl.sv
module smv_ctrl
    import smv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_start,
    input  logic       pipe_busy,
    output smv_state_e state_q,
    output logic       load_open
);
    smv_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   if (row_start) state_d = ST_STREAM;
            ST_STREAM: if (!row_start) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (row_start)       state_d = ST_STREAM;
                else if (!pipe_busy) state_d = ST_LOAD;
            end
            default:   state_d = ST_LOAD;
        endcase
    end

    always_comb begin
        load_open = (state_q == ST_LOAD) && !row_start;
    end
endmodule

// File: rtl/smv_array.sv
module smv_array
    import smv_pkg::*;
#(
    parameter int N      = 3,
    parameter int DATA_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int ACC_W = 2 * DATA_W + $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vec_wr,
    input  logic [IDX_W-1:0]           vec_idx,
    input  logic [DATA_W-1:0]          vec_data,
    input  logic                       row_start,
    input  logic [N-1:0][DATA_W-1:0]   a_lanes,
    output logic                       y_valid,
    output logic [ACC_W-1:0]           y_data
);
    logic [N-1:0][DATA_W-1:0] coef_q;
    logic [N-1:0]             vpipe_q;
    logic [ACC_W-1:0]         chain [0:N];
    smv_state_e               state_q;
    logic                     load_open;

    smv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_start (row_start),
        .pipe_busy (|vpipe_q),
        .state_q   (state_q),
        .load_open (load_open)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_q <= '0;
        end else if (load_open && vec_wr) begin
            for (int k = 0; k < N; k++) begin
                if (int'(vec_idx) == k) coef_q[k] <= vec_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe_q <= '0;
        end else begin
            vpipe_q[0] <= row_start;
            for (int k = 1; k < N; k++) begin
                vpipe_q[k] <= vpipe_q[k-1];
            end
        end
    end

    assign chain[0] = '0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cell
            smv_cell #(
                .DATA_W (DATA_W),
                .ACC_W  (ACC_W)
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .a_in     (a_lanes[g]),
                .coef     (coef_q[g]),
                .psum_in  (chain[g]),
                .psum_out (chain[g+1])
            );
        end
    endgenerate

    assign y_valid = vpipe_q[N-1];
    assign y_data  = chain[N];
endmodule

// File: rtl/smv_array_chk.sv
module smv_array_chk
    import smv_pkg::*;
#(
    parameter int N      = 3,
    parameter int DATA_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     row_start,
    input logic                     vec_wr,
    input logic [IDX_W-1:0]         vec_idx,
    input logic [DATA_W-1:0]        vec_data,
    input logic                     y_valid,
    input smv_state_e               state,
    input logic [N-1:0][DATA_W-1:0] coef
);
    logic [N-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q[0] <= row_start;
            for (int k = 1; k < N; k++) seen_q[k] <= seen_q[k-1];
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid == seen_q[N-1]);

    assert_no_idle_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == '0) |-> !y_valid);

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && vec_wr && !row_start && int'(vec_idx) < N)
        |=> coef[$past(vec_idx)] == $past(vec_data));

    assert_coef_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |=> $stable(coef));

    assert_start_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> $stable(coef));

    assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr && int'(vec_idx) >= N) |=> $stable(coef));

    assert_load_to_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && row_start) |=> state == ST_STREAM);

    assert_stream_to_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !row_start) |=> state == ST_DRAIN);

    assert_drain_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !row_start && seen_q != '0) |=> state == ST_DRAIN);
endmodule

bind smv_array smv_array_chk #(
    .N      (N),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_start (row_start),
    .vec_wr    (vec_wr),
    .vec_idx   (vec_idx),
    .vec_data  (vec_data),
    .y_valid   (y_valid),
    .state     (state_q),
    .coef      (coef_q)
);

// File: tb/smv_array_tb.sv
module smv_array_tb;
    localparam int N      = 3;
    localparam int DW     = 8;
    localparam int IDX_W  = 2;
    localparam int ACC_W  = 18;
    localparam int MAXR   = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 vec_wr = 1'b0;
    logic [IDX_W-1:0]     vec_idx = '0;
    logic [DW-1:0]        vec_data = '0;
    logic                 row_start = 1'b0;
    logic [N-1:0][DW-1:0] a_lanes = '0;
    logic                 y_valid;
    logic [ACC_W-1:0]     y_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int mat [0:MAXR-1][0:N-1];
    int vmod [0:N-1];
    int seed = 7;

    always #5 clk = ~clk;

    smv_array #(.N(N), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_wr    (vec_wr),
        .vec_idx   (vec_idx),
        .vec_data  (vec_data),
        .row_start (row_start),
        .a_lanes   (a_lanes),
        .y_valid   (y_valid),
        .y_data    (y_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_val();
        seed = (seed * 1103 + 12345) % 65521;
        return (seed % 256) - 128;
    endfunction

    function automatic int dot(input int r);
        int s = 0;
        for (int k = 0; k < N; k++) s += mat[r][k] * vmod[k];
        return s;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic vec_write(input int idx, input int val, input bit accept);
        vec_wr   = 1'b1;
        vec_idx  = IDX_W'(idx);
        vec_data = DW'(val);
        tick();
        vec_wr = 1'b0;
        if (accept) vmod[idx] = val;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Streams m rows of mat with the skew of R4 and checks every output cycle (R1, R2, R3).
    task automatic stream(input int m, input bit junk_wr);
        for (int c = 0; c <= m + N - 2; c++) begin
            row_start = (c < m);
            for (int k = 0; k < N; k++) begin
                int r = c - k;
                a_lanes[k] = (r >= 0 && r < m) ? DW'(mat[r][k]) : '0;
            end
            vec_wr   = junk_wr;
            vec_idx  = IDX_W'(c % N);
            vec_data = 8'h55;
            tick();
            begin
                int r = c + 1 - N;
                bit ev = (r >= 0 && r < m);
                check(y_valid == ev, "R2_R3 valid timing", int'(y_valid), int'(ev));
                if (ev) check(int'($signed(y_data)) == dot(r), "R1_R4 dot product",
                              int'($signed(y_data)), dot(r));
            end
        end
        row_start = 1'b0;
        a_lanes   = '0;
        vec_wr    = 1'b0;
    endtask

    task automatic fill_rand(input int m);
        for (int r = 0; r < m; r++)
            for (int k = 0; k < N; k++) mat[r][k] = next_val();
    endtask

    task automatic fill_const(input int m, input int val);
        for (int r = 0; r < m; r++)
            for (int k = 0; k < N; k++) mat[r][k] = val;
    endtask

    initial begin
        for (int k = 0; k < N; k++) vmod[k] = 0;
        repeat (3) @(negedge clk);
        check(y_valid == 1'b0, "R5 reset valid", int'(y_valid), 0);
        check(y_data == '0, "R5 reset data", int'(y_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: coefficients are zero after reset, so every result is zero
        fill_rand(2);
        stream(2, 1'b0);
        idle(2);

        // R1 R2 R3: basic load and back-to-back rows
        vec_write(0, 3, 1'b1);
        vec_write(1, -2, 1'b1);
        vec_write(2, 5, 1'b1);
        fill_rand(6);
        stream(6, 1'b0);
        idle(2);

        // R2: single row
        fill_rand(1);
        stream(1, 1'b0);
        idle(2);

        // R1: extreme operands, no overflow
        vec_write(0, -128, 1'b1);
        vec_write(1, -128, 1'b1);
        vec_write(2, -128, 1'b1);
        fill_const(3, -128);
        stream(3, 1'b0);
        fill_const(3, 127);
        stream(3, 1'b0);
        idle(2);

        // R6 R7: writes during a row start, streaming and draining are dropped
        vec_write(0, 11, 1'b1);
        vec_write(1, -7, 1'b1);
        vec_write(2, 4, 1'b1);
        fill_rand(5);
        stream(5, 1'b1);
        idle(2);
        fill_rand(4);
        stream(4, 1'b0);

        // R9: DRAIN-to-LOAD boundary, writes at c+N and c+N+1 dropped, c+N+2 lands
        vec_write(0, 99, 1'b0);
        vec_write(2, -99, 1'b0);
        vec_write(1, 23, 1'b1);
        fill_rand(4);
        stream(4, 1'b0);
        idle(2);

        // R8: out-of-range index changes nothing
        vec_write(3, 77, 1'b0);
        fill_rand(3);
        stream(3, 1'b0);
        idle(2);

        // R1 R4: near-exhaustive sweep over a set of coefficient values
        begin
            int vals [0:4] = '{-128, -1, 0, 1, 127};
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 5; b++)
                    for (int d = 0; d < 5; d++) begin
                        vec_write(0, vals[a], 1'b1);
                        vec_write(1, vals[b], 1'b1);
                        vec_write(2, vals[d], 1'b1);
                        fill_rand(4);
                        stream(4, 1'b0);
                        idle(2);
                    end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule